// File: doc/BRIEF.md
# Cross-Tile Response Voting Comparator

This block judges a scan test run on identical processing tiles in parallel. Every tile under test is fed the same stimuli, so a healthy tile returns the same response word at each position. The comparator has no stored expected responses. It collects one word from each active tile at the same position and compares the words with each other. A tile that disagrees with the others is named as faulty by majority vote, which assumes that at most one tile is faulty at a time.

Software starts a run with a pulse on `start`. With the pulse it selects two-tile or three-tile mode and sets the number of words in the run. While the words agree, the block keeps accepting words and signals that the test may continue. At the first disagreement it stops taking words, raises a halt, and latches a status word that software reads. This status word holds a done flag, a fault flag, a verdict code, the faulty tile index and a word index. If every word agrees, the run ends with a pass verdict.

Top module: `resp_vote_cmp`

## Requirements
- R1: After a synchronous reset, `busy`, `halt`, `done`, `faulty_tile`, `status` and `tile_ready` are all zero.
- R2: A `start` pulse clears `status`, `halt` and `done` and sets `busy`, all visible one cycle later. It latches the mode and the run length.
- R3: A word position is compared only once every active tile holds a word. A tile holding a word shows `tile_ready` low until that position has been compared.
- R4: In three-tile mode, a run of N words that all agree ends with `done`=1, fault=0, verdict code 0 (pass), tile field 3 and word index N in the status word.
- R5: In three-tile mode, if exactly one tile differs from the other two, which agree, the verdict code is 1. The tile field and `faulty_tile` give that tile's index (0, 1 or 2).
- R6: In three-tile mode, if all three words differ from one another, the verdict code is 3 (multiple faults) and the tile field is 3.
- R7: In two-tile mode, a mismatch gives verdict code 2 (faulty tile cannot be named) and tile field 3.
- R8: On the first mismatch, `halt` and `done` rise, `busy` falls and every `tile_ready` goes low. The word index gives the 0-based position of the failing word. `halt` holds until the next `start`.
- R9: In two-tile mode, tile 2 is never made ready and its data has no effect on the verdict.
- R10: A run length of zero ends at once with a pass verdict and word index 0.
- R11: Status word layout: bit CNT_W+5 is done, bit CNT_W+4 is fault, bits CNT_W+3:CNT_W+2 are the verdict code, bits CNT_W+1:CNT_W are the tile field, and bits CNT_W-1:0 are the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run and clear the status word |
| three_tiles | input | 1 | Mode latched at start: 1 = tiles 0..2, 0 = tiles 0..1 |
| test_len | input | CNT_W | Number of words in the run, latched at start |
| tile_valid | input | 3 | Per-tile response word valid |
| tile_data | input | 3*DATA_W | Response words, tile i in bits i*DATA_W +: DATA_W |
| tile_ready | output | 3 | Per-tile word accepted when valid and ready |
| busy | output | 1 | Run in progress with no difference found; testing may continue |
| halt | output | 1 | A difference was found; held until the next start |
| done | output | 1 | The run has ended |
| faulty_tile | output | 2 | Latched tile field (3 = none named) |
| status | output | CNT_W+6 | Readable status word, layout per R11 |

## Verification
The case that needs the most care is a mismatch on the final word of a run. In that cycle the word count reaches the run length at the same time as the vote fails, and the verdict must be the fault with the index of that word, never a pass. The bench places injected faults at random positions, including the last position. It compares the latched status against a verdict worked out by a bench-side vote model. The bench also lets tiles present their words with random independent gaps, so that the final word of one tile can arrive cycles before the others.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  typedef enum logic [1:0] {
    VC_PASS   = 2'd0,
    VC_SINGLE = 2'd1,
    VC_UNDIAG = 2'd2,
    VC_MULTI  = 2'd3
  } verdict_t;

  localparam logic [1:0] NO_TILE = 2'd3;
  localparam int unsigned NUM_TILES = 3;

  typedef struct packed {
    logic     mismatch;
    verdict_t code;
    logic [1:0] tile;
  } vote_t;

endpackage

// File: rtl/rvc_slot.sv
module rvc_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              vld,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
      dout <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (en && vld && !full) begin
      full <= 1'b1;
      dout <= din;
    end
  end

endmodule

// File: rtl/rvc_vote.sv
module rvc_vote
  import rvc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              three,
  input  logic [DATA_W-1:0] w0,
  input  logic [DATA_W-1:0] w1,
  input  logic [DATA_W-1:0] w2,
  output vote_t             res
);

  logic e01, e02, e12;

  always_comb begin
    e01 = (w0 == w1);
    e02 = (w0 == w2);
    e12 = (w1 == w2);
    res = '{mismatch: 1'b0, code: VC_PASS, tile: NO_TILE};
    if (!three) begin
      if (!e01) res = '{mismatch: 1'b1, code: VC_UNDIAG, tile: NO_TILE};
    end else if (e01 && e02) begin
      res = '{mismatch: 1'b0, code: VC_PASS, tile: NO_TILE};
    end else if (e12) begin
      res = '{mismatch: 1'b1, code: VC_SINGLE, tile: 2'd0};
    end else if (e02) begin
      res = '{mismatch: 1'b1, code: VC_SINGLE, tile: 2'd1};
    end else if (e01) begin
      res = '{mismatch: 1'b1, code: VC_SINGLE, tile: 2'd2};
    end else begin
      res = '{mismatch: 1'b1, code: VC_MULTI, tile: NO_TILE};
    end
  end

endmodule

// File: rtl/rvc_ctrl.sv
module rvc_ctrl
  import rvc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             three_in,
  input  logic [CNT_W-1:0] len_in,
  input  logic             all_full,
  input  vote_t            vres,
  output logic             busy,
  output logic             halt,
  output logic             done,
  output logic             three_q,
  output logic             consume,
  output verdict_t         code_q,
  output logic [1:0]       tile_q,
  output logic [CNT_W-1:0] idx_q
);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end  = (cnt == len_q);
  assign consume = busy && all_full && !at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      halt    <= 1'b0;
      done    <= 1'b0;
      three_q <= 1'b0;
      len_q   <= '0;
      cnt     <= '0;
      code_q  <= VC_PASS;
      tile_q  <= 2'd0;
      idx_q   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      halt    <= 1'b0;
      done    <= 1'b0;
      three_q <= three_in;
      len_q   <= len_in;
      cnt     <= '0;
      code_q  <= VC_PASS;
      tile_q  <= 2'd0;
      idx_q   <= '0;
    end else if (busy) begin
      if (at_end) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        code_q <= VC_PASS;
        tile_q <= NO_TILE;
        idx_q  <= cnt;
      end else if (all_full) begin
        if (vres.mismatch) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          halt   <= 1'b1;
          code_q <= vres.code;
          tile_q <= vres.tile;
          idx_q  <= cnt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/resp_vote_cmp.sv
module resp_vote_cmp
  import rvc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          three_tiles,
  input  logic [CNT_W-1:0]              test_len,
  input  logic [NUM_TILES-1:0]          tile_valid,
  input  logic [NUM_TILES*DATA_W-1:0]   tile_data,
  output logic [NUM_TILES-1:0]          tile_ready,
  output logic                          busy,
  output logic                          halt,
  output logic                          done,
  output logic [1:0]                    faulty_tile,
  output logic [CNT_W+5:0]              status
);

  localparam int unsigned ST_W = CNT_W + 6;

  logic [NUM_TILES-1:0] full;
  logic [NUM_TILES-1:0] active;
  logic [DATA_W-1:0]    held [NUM_TILES];
  logic                 three_q;
  logic                 consume;
  logic                 all_full;
  vote_t                vres;
  verdict_t             code_q;
  logic [1:0]           tile_q;
  logic [CNT_W-1:0]     idx_q;

  assign active = {three_q, 2'b11};

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_slot
    rvc_slot #(.DATA_W(DATA_W)) u_slot (
      .clk  (clk),
      .rst  (rst),
      .clr  (start),
      .en   (busy && active[t]),
      .vld  (tile_valid[t]),
      .din  (tile_data[t*DATA_W +: DATA_W]),
      .take (consume),
      .full (full[t]),
      .dout (held[t])
    );
    assign tile_ready[t] = busy && active[t] && !full[t];
  end

  assign all_full = &(full | ~active);

  rvc_vote #(.DATA_W(DATA_W)) u_vote (
    .three (three_q),
    .w0    (held[0]),
    .w1    (held[1]),
    .w2    (held[2]),
    .res   (vres)
  );

  rvc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .three_in (three_tiles),
    .len_in   (test_len),
    .all_full (all_full),
    .vres     (vres),
    .busy     (busy),
    .halt     (halt),
    .done     (done),
    .three_q  (three_q),
    .consume  (consume),
    .code_q   (code_q),
    .tile_q   (tile_q),
    .idx_q    (idx_q)
  );

  assign faulty_tile = tile_q;
  assign status = ST_W'({done, halt, code_q, tile_q, idx_q});

endmodule

// File: rtl/rvc_checker.sv
module rvc_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [2:0]       tile_ready,
  input logic             busy,
  input logic             halt,
  input logic             done,
  input logic [1:0]       faulty_tile,
  input logic [CNT_W+5:0] status,
  input logic             three_q
);

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tile_ready == 3'b000)); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halt && !start) |=> halt); // R8
  AST_HALT_MEANS_FAULT: assert property (@(posedge clk) disable iff (rst)
    halt |-> (done && status[CNT_W+4])); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (status == '0 && !halt && busy)); // R2
  AST_TWO_TILE_T2_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busy && !three_q) |-> !tile_ready[2]); // R9
  AST_SINGLE_NAMED: assert property (@(posedge clk) disable iff (rst)
    (done && status[CNT_W+3:CNT_W+2] == 2'd1) |-> (faulty_tile != 2'd3)); // R5
  AST_NOT_BUSY_AND_DONE: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R4

endmodule

bind resp_vote_cmp rvc_checker #(.CNT_W(CNT_W)) u_rvc_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .tile_ready  (tile_ready),
  .busy        (busy),
  .halt        (halt),
  .done        (done),
  .faulty_tile (faulty_tile),
  .status      (status),
  .three_q     (three_q)
);

// File: tb/test_resp_vote_cmp.sv
`timescale 1ns/1ps
module test_resp_vote_cmp;

  localparam int DW = 32;
  localparam int CW = 16;
  localparam int MAXW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          three_tiles = 1'b1;
  logic [CW-1:0] test_len = '0;
  logic [2:0]    vld = '0;
  logic [DW-1:0] dat [3];
  logic [2:0]    tile_ready;
  logic          busy, halt, done;
  logic [1:0]    faulty_tile;
  logic [CW+5:0] status;

  logic [DW-1:0] wd [3][MAXW];
  int            nw;
  int            checks = 0;
  int            fails = 0;
  int            cyc = 0;

  always #2 clk = ~clk;

  resp_vote_cmp #(.DATA_W(DW), .CNT_W(CW)) i_resp_vote_cmp (
    .clk(clk), .rst(rst), .start(start), .three_tiles(three_tiles),
    .test_len(test_len), .tile_valid(vld), .tile_data({dat[2], dat[1], dat[0]}),
    .tile_ready(tile_ready), .busy(busy), .halt(halt), .done(done),
    .faulty_tile(faulty_tile), .status(status)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // {code, tile}
  function automatic logic [3:0] model(bit three, logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    if (!three) return (a == b) ? 4'b00_11 : 4'b10_11;
    if (a == b && a == c) return 4'b00_11;
    if (b == c) return 4'b01_00;
    if (a == c) return 4'b01_01;
    if (a == b) return 4'b01_10;
    return 4'b11_11;
  endfunction

  task automatic feed(input int t);
    for (int w = 0; w < nw; w++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      if (halt || done) break;
      vld[t] = 1'b1;
      dat[t] = wd[t][w];
      while (!tile_ready[t] && !halt && !done) @(negedge clk);
      if (!tile_ready[t]) begin vld[t] = 1'b0; break; end
      @(negedge clk);
      vld[t] = 1'b0;
    end
  endtask

  task automatic do_start(input bit three, input int n);
    @(negedge clk);
    three_tiles = three;
    test_len = CW'(n);
    nw = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(status == '0 && !halt && busy, "R2 start clears", status, 0);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  task automatic run(input bit three, input int n, input string tag);
    logic [3:0] exp = 4'b00_11;
    int eidx = n;
    for (int w = 0; w < n; w++) begin
      logic [3:0] r = model(three, wd[0][w], wd[1][w], wd[2][w]);
      if (r[3:2] != 2'b00) begin exp = r; eidx = w; break; end
    end
    do_start(three, n);
    fork feed(0); feed(1); feed(2); join
    wait_done();
    chk(done == 1'b1, {tag, " R4 done"}, done, 1);
    chk(status[CW+4] == (exp[3:2] != 2'b00), {tag, " R8 fault bit"}, status[CW+4], exp[3:2] != 0);
    chk(halt == (exp[3:2] != 2'b00) && !busy && tile_ready == 3'b000, {tag, " R8 halt/busy/ready"},
        {halt, busy, tile_ready}, {exp[3:2] != 0, 4'b0});
    chk(status[CW+3:CW+2] == exp[3:2], {tag, " R5 R6 R7 verdict code"}, status[CW+3:CW+2], exp[3:2]);
    chk(status[CW+1:CW] == exp[1:0] && faulty_tile == exp[1:0], {tag, " R5 R11 tile field"},
        status[CW+1:CW], exp[1:0]);
    chk(status[CW-1:0] == CW'(eidx), {tag, " R8 R10 word index"}, status[CW-1:0], eidx);
  endtask

  task automatic fill_agree(input int n);
    for (int w = 0; w < n; w++) begin
      logic [DW-1:0] v = $urandom;
      for (int t = 0; t < 3; t++) wd[t][w] = v;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int t = 0; t < 3; t++) dat[t] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(status == '0 && !busy && !halt && !done && faulty_tile == 2'd0 && tile_ready == 3'b000,
        "R1 reset state", {busy, halt, done, tile_ready}, 0);

    // R4 all agree, three tiles
    fill_agree(8);
    run(1'b1, 8, "pass3");

    // R5 single odd tile, each index, last word position included
    for (int k = 0; k < 3; k++) begin
      fill_agree(6);
      wd[k][5] = wd[k][5] ^ 32'h0000_0100;
      run(1'b1, 6, "single_last");
    end

    // R6 all three differ
    fill_agree(5);
    wd[1][2] = wd[1][2] ^ 32'h1;
    wd[2][2] = wd[2][2] ^ 32'h2;
    run(1'b1, 5, "multi");

    // R7 two-tile mismatch
    fill_agree(5);
    wd[1][1] = ~wd[1][1];
    run(1'b0, 5, "undiag");

    // R9 tile 2 differs but is ignored in two-tile mode
    fill_agree(6);
    for (int w = 0; w < 6; w++) wd[2][w] = ~wd[2][w];
    run(1'b0, 6, "R9 ignore_t2");

    // R10 zero length
    run(1'b1, 0, "R10 zero_len");

    // R3 compare waits for every active tile
    fill_agree(1);
    do_start(1'b1, 1);
    fork feed(0); feed(1); join
    repeat (4) @(negedge clk);
    chk(!done && busy && tile_ready == 3'b100, "R3 waits for tile 2", {done, busy, tile_ready}, 6'b01_100);
    feed(2);
    wait_done();
    chk(done && !halt && status[CW-1:0] == 1, "R3 R4 compare after last tile", status, 1);

    // random runs
    for (int r = 0; r < 40; r++) begin
      bit three = 1'($urandom_range(0, 1));
      int n = $urandom_range(1, MAXW);
      int kind = $urandom_range(0, 3);
      int pos = $urandom_range(0, n - 1);
      fill_agree(n);
      if (kind == 1) wd[$urandom_range(0, three ? 2 : 1)][pos] ^= (32'h1 << $urandom_range(0, 31));
      if (kind == 2) begin
        wd[0][pos] ^= 32'h10;
        wd[1][pos] ^= 32'h20;
      end
      if (!three) for (int w = 0; w < n; w++) wd[2][w] = $urandom;
      run(three, n, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule